// File: doc/BRIEF.md
# Interleaving SPI Stream Master

This block is an SPI master (mode 0, 8-bit characters, most significant bit first) that streams a payload to a slave whose clock input is gated so that the slave sees only every other character. After each payload character the master sends one filler character, with no idle time between any two characters of a frame. Because the slave's clock is blocked during the filler slots, the slave gets a whole character time to digest each byte and prepare its reply. The master therefore runs at a much higher SCK rate than the slave's software could otherwise follow.

Payload bytes enter through a valid/ready handshake. The byte shifted in from MISO during each payload slot is returned through a second valid/ready handshake. Bytes that arrive during filler slots are dropped. Slave select stays low for the whole frame.

A frame ends when, at the close of a filler slot, no next payload byte can be taken. This happens when no byte is offered or when the previous received byte has not been collected. The master does not insert a gap inside a frame. It raises slave select, waits at least one full SCK period, and then starts a new frame when data is available. The SCK half-period is set in system clock cycles by the `half_div` input, which is sampled when a frame starts.

Top module: `ilv_spi_master`

## Requirements
- R1: After reset, `ss_n` is 1, `sclk` is 0, `mosi` is 0, `rx_valid` is 0 and `tx_ready` is 1.
- R2: SCK idles low. MOSI changes only together with a falling SCK edge, or at the start of a frame while SCK is low, so MOSI is stable whenever SCK is high. MISO is sampled at each rising SCK edge.
- R3: Each character carries 8 bits, most significant bit first. Payload bytes appear on MOSI in the order they were accepted, in the even slots of the frame (slot 0, 2, 4, … counted from the fall of `ss_n`).
- R4: Every payload slot is followed by exactly one filler slot carrying the `FILL_BYTE` parameter (default 0x00). A frame that carries k payload bytes holds exactly 2k characters.
- R5: Within a frame, consecutive rising SCK edges are exactly 2*(half_div+1) clock cycles apart, including across character boundaries. The first rising edge comes half_div+1 cycles after `ss_n` falls. `half_div` is the value present when the frame started.
- R6: The byte shifted in during each payload slot is delivered once, in order, on `rx_data` with `rx_valid`. It is removed when `rx_ready` is high. `rx_data` is stable while `rx_valid` is high and `rx_ready` low. Bytes from filler slots are never delivered.
- R7: If, at the end of a filler slot, `tx_valid` is low or the received byte is still held, `ss_n` goes high at that edge. SCK stays low whenever `ss_n` is high.
- R8: Between two frames, `ss_n` stays high for at least 2*(half_div+1) clock cycles, using the divider value of the frame that ended.
- R9: `tx_ready` is high only while no received byte is held. A frame starts only from idle, when `tx_valid` is high and no received byte is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | DIV_W | SCK half-period in clock cycles, minus one |
| tx_data | input | 8 | Payload byte offered |
| tx_valid | input | 1 | Payload byte offered is valid |
| tx_ready | output | 1 | Payload byte is taken at this edge when valid |
| rx_data | output | 8 | Byte received in a payload slot |
| rx_valid | output | 1 | Received byte is available |
| rx_ready | input | 1 | Consumer takes the received byte |
| sclk | output | 1 | SPI serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | 1 | Slave select, active low |

## Verification
The bench builds the master with `DIV_W` = 4 and `FILL_BYTE` = 0x5A. The narrow divider keeps even the slowest setting (half-period of 16 cycles) short enough that many frames fit in a run, and it makes both extremes of the divider reachable: half_div = 0, where SCK toggles every cycle, and half_div = 15. A non-zero filler value can be told apart from zero payload bytes and from an idle MOSI line, so a misplaced or missing filler slot shows up as a wrong byte. Random frame lengths and divider values are mixed with back-to-back frames that probe the minimum select gap, and with a held receive byte that forces a frame to end after a single payload slot.

// File: rtl/ilv_spi_pkg.sv
`timescale 1ns/1ps
package ilv_spi_pkg;

    localparam int unsigned CHAR_BITS = 8;
    localparam int unsigned BIT_IDX_W = $clog2(CHAR_BITS);

    typedef logic [CHAR_BITS-1:0] char_t;
    typedef logic [BIT_IDX_W-1:0] bit_idx_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } ctrl_state_t;

    typedef enum logic {
        SLOT_PAY  = 1'b0,
        SLOT_FILL = 1'b1
    } slot_kind_t;

    // Per-cycle actions issued by the controller to the datapath.
    typedef struct packed {
        logic load;      // load a new character into the transmit shifter
        logic load_pay;  // the new character is a payload byte (else filler)
        logic rise;      // SCK rises at this edge: sample MISO
        logic fall;      // SCK falls at this edge: advance MOSI
        logic push;      // a payload character just completed
    } step_t;

    function automatic logic is_last_bit(bit_idx_t idx);
        return idx == bit_idx_t'(CHAR_BITS - 1);
    endfunction

endpackage

// File: rtl/ilv_spi_halfclk.sv
`timescale 1ns/1ps
module ilv_spi_halfclk #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;

    // While stopped the counter and the latched divider track the input;
    // once running, the latched divider sets every half-period.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            div_q <= '0;
        end else if (!run) begin
            cnt_q <= half_div;
            div_q <= half_div;
        end else if (cnt_q == '0) begin
            cnt_q <= div_q;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/ilv_spi_shifter.sv
`timescale 1ns/1ps
module ilv_spi_shifter
    import ilv_spi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  char_t load_val,
    input  logic  rise,
    input  logic  fall,
    input  logic  miso,
    output logic  mosi_bit,
    output char_t rx_char,
    output logic  last_bit
);

    char_t    tx_q;
    char_t    rx_q;
    bit_idx_t idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            rx_q  <= '0;
            idx_q <= '0;
        end else begin
            if (load) begin
                tx_q  <= load_val;
                idx_q <= '0;
            end else if (fall) begin
                tx_q  <= {tx_q[CHAR_BITS-2:0], 1'b0};
                idx_q <= idx_q + 1'b1;
            end
            if (rise) begin
                rx_q <= {rx_q[CHAR_BITS-2:0], miso};
            end
        end
    end

    assign mosi_bit = tx_q[CHAR_BITS-1];
    assign rx_char  = rx_q;
    assign last_bit = is_last_bit(idx_q);

endmodule

// File: rtl/ilv_spi_rxhold.sv
`timescale 1ns/1ps
module ilv_spi_rxhold
    import ilv_spi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  char_t push_data,
    input  logic  rx_ready,
    output logic  rx_valid,
    output char_t rx_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else if (push) begin
            rx_valid <= 1'b1;
            rx_data  <= push_data;
        end else if (rx_valid && rx_ready) begin
            rx_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/ilv_spi_ctrl.sv
`timescale 1ns/1ps
module ilv_spi_ctrl
    import ilv_spi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  tx_valid,
    input  logic  rx_full,
    input  logic  last_bit,
    output logic  run,
    output logic  sclk,
    output logic  ss_n,
    output logic  tx_ready,
    output step_t step
);

    ctrl_state_t state_q;
    slot_kind_t  slot_q;
    logic        sclk_q;
    logic        ss_n_q;
    logic        hold_q;

    logic shifting;
    logic char_end;
    logic take_ok;
    logic start;
    logic refill;
    logic stop;

    always_comb begin
        shifting = (state_q == ST_SHIFT);
        take_ok  = tx_valid && !rx_full;
        step.rise = shifting && tick && !sclk_q;
        step.fall = shifting && tick && sclk_q;
        char_end  = step.fall && last_bit;
        start     = (state_q == ST_IDLE) && take_ok;
        refill    = char_end && (slot_q == SLOT_FILL) && take_ok;
        stop      = char_end && (slot_q == SLOT_FILL) && !take_ok;
        step.load_pay = start || refill;
        step.load     = start || refill || (char_end && (slot_q == SLOT_PAY));
        step.push     = char_end && (slot_q == SLOT_PAY);
        tx_ready = !rx_full &&
                   ((state_q == ST_IDLE) || (char_end && (slot_q == SLOT_FILL)));
        run  = (state_q != ST_IDLE);
        sclk = sclk_q;
        ss_n = ss_n_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            slot_q  <= SLOT_PAY;
            sclk_q  <= 1'b0;
            ss_n_q  <= 1'b1;
            hold_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    sclk_q <= 1'b0;
                    if (start) begin
                        state_q <= ST_SHIFT;
                        ss_n_q  <= 1'b0;
                        slot_q  <= SLOT_PAY;
                    end
                end
                ST_SHIFT: begin
                    if (step.rise) begin
                        sclk_q <= 1'b1;
                    end
                    if (step.fall) begin
                        sclk_q <= 1'b0;
                    end
                    if (step.load) begin
                        slot_q <= step.load_pay ? SLOT_PAY : SLOT_FILL;
                    end
                    if (stop) begin
                        state_q <= ST_HOLD;
                        ss_n_q  <= 1'b1;
                        hold_q  <= 1'b0;
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        hold_q <= !hold_q;
                        if (hold_q) begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    ss_n_q  <= 1'b1;
                    sclk_q  <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ilv_spi_master.sv
`timescale 1ns/1ps
module ilv_spi_master
    import ilv_spi_pkg::*;
#(
    parameter int unsigned DIV_W     = 8,
    parameter logic [7:0]  FILL_BYTE = 8'h00
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DIV_W-1:0]     half_div,
    input  logic [CHAR_BITS-1:0] tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    output logic [CHAR_BITS-1:0] rx_data,
    output logic                 rx_valid,
    input  logic                 rx_ready,
    output logic                 sclk,
    output logic                 mosi,
    input  logic                 miso,
    output logic                 ss_n
);

    step_t step;
    logic  tick;
    logic  run;
    logic  last_bit;
    logic  mosi_bit;
    char_t rx_char;
    char_t load_val;

    ilv_spi_halfclk #(.DIV_W(DIV_W)) u_halfclk (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .half_div (half_div),
        .tick     (tick)
    );

    ilv_spi_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .tx_valid (tx_valid),
        .rx_full  (rx_valid),
        .last_bit (last_bit),
        .run      (run),
        .sclk     (sclk),
        .ss_n     (ss_n),
        .tx_ready (tx_ready),
        .step     (step)
    );

    assign load_val = step.load_pay ? tx_data : char_t'(FILL_BYTE);

    ilv_spi_shifter u_shifter (
        .clk      (clk),
        .rst      (rst),
        .load     (step.load),
        .load_val (load_val),
        .rise     (step.rise),
        .fall     (step.fall),
        .miso     (miso),
        .mosi_bit (mosi_bit),
        .rx_char  (rx_char),
        .last_bit (last_bit)
    );

    ilv_spi_rxhold u_rxhold (
        .clk       (clk),
        .rst       (rst),
        .push      (step.push),
        .push_data (rx_char),
        .rx_ready  (rx_ready),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data)
    );

    assign mosi = !ss_n && mosi_bit;

endmodule

// File: rtl/ilv_spi_master_chk.sv
`timescale 1ns/1ps
module ilv_spi_master_chk #(
    parameter int unsigned DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [DIV_W-1:0] half_div,
    input logic             sclk,
    input logic             ss_n,
    input logic             mosi,
    input logic             tx_ready,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic [7:0]       rx_data
);

    localparam int unsigned GAP_W = DIV_W + 3;

    logic [GAP_W-1:0] gap_cnt;
    logic [GAP_W-1:0] gap_need;
    logic [DIV_W-1:0] lat_div;
    logic             ss_prev;
    logic             seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt <= '0;
            lat_div <= '0;
            ss_prev <= 1'b1;
            seen    <= 1'b0;
        end else begin
            ss_prev <= ss_n;
            if (ss_n) begin
                if (gap_cnt != '1) begin
                    gap_cnt <= gap_cnt + 1'b1;
                end
            end else begin
                gap_cnt <= '0;
            end
            if (ss_prev && !ss_n) begin
                lat_div <= half_div;
                seen    <= 1'b1;
            end
        end
    end

    assign gap_need = (GAP_W'(lat_div) + 1'b1) << 1;

    AST_SCK_LOW_DESELECT: assert property (@(posedge clk) disable iff (rst)
        ss_n |-> !sclk);  // R7

    AST_MOSI_STABLE_SCK_HIGH: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi));  // R2

    AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));  // R6

    AST_READY_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> !rx_valid);  // R9

    AST_SELECT_GAP: assert property (@(posedge clk) disable iff (rst)
        (ss_prev && !ss_n && seen) |-> (gap_cnt >= gap_need));  // R8

endmodule

bind ilv_spi_master ilv_spi_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .half_div (half_div),
    .sclk     (sclk),
    .ss_n     (ss_n),
    .mosi     (mosi),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data)
);

// File: tb/ilv_spi_master_test.sv
`timescale 1ns/1ps
module ilv_spi_master_test;

    localparam int unsigned DW     = 4;
    localparam logic [7:0]  FILL   = 8'h5A;
    localparam longint      PERIOD = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] half_div = '0;
    logic [7:0]    tx_data = 8'h00;
    logic          tx_valid = 1'b0;
    logic          tx_ready;
    logic [7:0]    rx_data;
    logic          rx_valid;
    logic          rx_ready = 1'b1;
    logic          sclk;
    logic          mosi;
    logic          miso = 1'b0;
    logic          ss_n;

    always #10 clk = ~clk;

    ilv_spi_master #(.DIV_W(DW), .FILL_BYTE(FILL)) uut (
        .clk(clk), .rst(rst), .half_div(half_div),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] miso_pat(input int g);
        logic [7:0] v;
        v = 8'(g * 29 + 60);
        return v ^ 8'(g >> 2);
    endfunction

    // Scoreboard storage
    logic [7:0] sent_b [0:511];
    logic [7:0] exp_rx [0:511];
    int n_sent = 0;
    int mon_pay = 0;
    int rx_w = 0;
    int rx_r = 0;

    // Slave model: gated-clock view of every slot, MISO changed on falls
    int         sl_bits = 0;
    int         sl_slot = 0;
    int         gslot = 0;
    int         frame_len = 0;
    logic [7:0] sl_in = 8'h00;
    logic [7:0] sl_out = 8'h00;
    logic [DW-1:0] frame_div = '0;
    logic [DW-1:0] prev_div = '0;
    longint     t_fall = 0;
    longint     t_rise_ss = 0;
    longint     t_last = 0;
    bit         have_prev = 1'b0;

    always @(negedge ss_n) begin
        if (!rst) begin
            if (have_prev)
                chk(($time - t_rise_ss) >= 2 * (longint'(prev_div) + 1) * PERIOD,
                    "R8 select high gap", $time - t_rise_ss,
                    2 * (longint'(prev_div) + 1) * PERIOD);
            frame_div = half_div;
            t_fall    = $time;
            sl_bits   = 0;
            sl_slot   = 0;
            sl_out    = miso_pat(gslot);
            miso      = sl_out[7];
        end
    end

    always @(posedge ss_n) begin
        if (!rst) begin
            frame_len = sl_slot;
            t_rise_ss = $time;
            prev_div  = frame_div;
            have_prev = 1'b1;
        end
    end

    always @(posedge sclk) begin
        if (!ss_n && !rst) begin
            if (sl_bits == 0 && sl_slot == 0)
                chk(($time - t_fall) == (longint'(frame_div) + 1) * PERIOD,
                    "R5 first edge delay", $time - t_fall,
                    (longint'(frame_div) + 1) * PERIOD);
            else
                chk(($time - t_last) == 2 * (longint'(frame_div) + 1) * PERIOD,
                    "R5 edge spacing", $time - t_last,
                    2 * (longint'(frame_div) + 1) * PERIOD);
            t_last = $time;
            sl_in  = {sl_in[6:0], mosi};
            sl_bits++;
            if (sl_bits == 8) begin
                if (sl_slot % 2 == 0) begin
                    chk(sl_in == sent_b[mon_pay], "R3 payload byte on MOSI",
                        sl_in, sent_b[mon_pay]);
                    mon_pay++;
                    exp_rx[rx_w] = sl_out;
                    rx_w++;
                end else begin
                    chk(sl_in == FILL, "R4 filler byte on MOSI", sl_in, FILL);
                end
                sl_slot++;
                gslot++;
                sl_bits = 0;
                sl_out  = miso_pat(gslot);
            end
        end
    end

    always @(negedge sclk) begin
        if (!ss_n && !rst) miso = sl_out[3'(7 - sl_bits)];
    end

    // Line monitors between edges
    int   r2_err = 0;
    int   r7_err = 0;
    logic prev_mosi = 1'b0;

    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (sclk && (mosi !== prev_mosi)) r2_err++;
                if (ss_n && sclk) r7_err++;
            end
            prev_mosi = mosi;
        end
    end

    // Receive-side consumer check
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rx_valid && rx_ready) begin
                if (rx_r < rx_w)
                    chk(rx_data == exp_rx[rx_r], "R6 received payload byte",
                        rx_data, exp_rx[rx_r]);
                else
                    chk(1'b0, "R6 byte delivered beyond payload slots", rx_r, rx_w);
                rx_r++;
            end
        end
    end

    task automatic push_byte();
        tx_data  = 8'($urandom);
        tx_valid = 1'b1;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        @(posedge clk);
        #1;
        sent_b[n_sent] = tx_data;
        n_sent++;
    endtask

    task automatic send_frame(input int k);
        for (int i = 0; i < k; i++) push_byte();
        tx_valid = 1'b0;
        @(posedge ss_n);
        #1;
        chk(frame_len == 2 * k, "R4 characters per frame", frame_len, 2 * k);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog R1-all actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1337));
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(ss_n == 1'b1,     "R1 reset ss_n",     ss_n,     1);
        chk(sclk == 1'b0,     "R1 reset sclk",     sclk,     0);
        chk(mosi == 1'b0,     "R1 reset mosi",     mosi,     0);
        chk(rx_valid == 1'b0, "R1 reset rx_valid", rx_valid, 0);
        chk(tx_ready == 1'b1, "R1 reset tx_ready", tx_ready, 1);

        // Directed: fastest divider, then back-to-back frames, then slowest
        @(posedge clk); #1;
        half_div = 4'd0;
        send_frame(1);
        send_frame(3);
        send_frame(2);
        repeat (10) @(posedge clk); #1;
        half_div = 4'd15;
        send_frame(2);

        // Directed: held receive byte ends the frame after one payload slot
        repeat (10) @(posedge clk); #1;
        half_div = 4'd2;
        rx_ready = 1'b0;
        push_byte();
        tx_data = 8'($urandom);
        tx_valid = 1'b1;
        @(posedge ss_n);
        #1;
        chk(frame_len == 2, "R7 frame ends with byte held", frame_len, 2);
        repeat (40) @(negedge clk);
        chk(ss_n == 1'b1,     "R9 no frame while byte held", ss_n, 1);
        chk(tx_ready == 1'b0, "R9 tx_ready low while byte held", tx_ready, 0);
        chk(rx_valid == 1'b1, "R6 held byte still offered", rx_valid, 1);
        chk(rx_data == exp_rx[rx_r], "R6 held byte value", rx_data, exp_rx[rx_r]);
        @(posedge clk); #1;
        rx_ready = 1'b1;
        push_byte();
        push_byte();
        tx_valid = 1'b0;
        @(posedge ss_n);
        #1;
        chk(frame_len == 4, "R7 frame after release", frame_len, 4);

        // Constrained random frames
        for (int f = 0; f < 18; f++) begin
            if ($urandom % 3 != 0) begin
                repeat (1 + $urandom % 20) @(posedge clk);
                #1;
                half_div = DW'($urandom);
            end
            send_frame(1 + int'($urandom % 6));
        end

        repeat (50) @(negedge clk);
        chk(r2_err == 0, "R2 MOSI changed while SCK high", r2_err, 0);
        chk(r7_err == 0, "R7 SCK high while deselected", r7_err, 0);
        chk(rx_r == rx_w, "R6 all payload replies delivered", rx_r, rx_w);
        chk(mon_pay == n_sent, "R3 all payload bytes on wire", mon_pay, n_sent);
        summary();
        $finish;
    end

endmodule